// File: doc/BRIEF.md
# Streaming Profile Detrend and Correlator

This block takes in one fringe profile at a time, one unsigned pixel intensity per clock. The first pixel is flagged with a start marker and the last with an end marker. While the pixels arrive, it stores them and keeps running sums. When the profile is complete, it fits a least-squares straight line to the intensities. It then subtracts that line from every stored pixel. From the detrended samples it finds half their peak-to-peak swing. It also forms two dot products: one with a sine coefficient table and one with a cosine coefficient table. Both tables hold one entry per pixel index and are written through a simple port before the profile is sent.

All arithmetic is fixed-point integer. The line fit needs no divider. The x-axis spread of the profile depends only on the profile length, so its reciprocal, and the reciprocal of the length, are elaboration-time constants. The fit therefore reduces to two multiplies. The results appear together with a one-cycle done strobe. A downstream phase search uses them, and it lies outside this block.

Each profile must be followed by at least NPIX+3 idle cycles. Pixels that arrive while a profile is being processed are discarded.

Top module: `profile_fit_top`

## Requirements
- R1: After reset, `done` is 0 and `isSum`, `icSum` and `amp` are all 0.
- R2: A profile opens on a valid pixel with `pixSop`=1, which becomes index 0. Valid pixels are ignored while no profile is open. A `pixSop` inside an open profile discards it and restarts at index 0.
- R3: A profile is accepted only when `pixEop` comes with exactly the NPIX-th pixel. An end marker on any other pixel, or a profile running past NPIX pixels, is dropped: no `done` is produced and the outputs keep their previous values.
- R4: Let S = sum of I[i] and T = sum of i*I[i]. With D = NPIX*(NPIX^2-1)/6, the fit computes slopeQ = (2T-(NPIX-1)*S)*round(2^FRAC/D) and meanQ = S*round(2^FRAC/NPIX). Here round(a/b) means floor((a+floor(b/2))/b).
- R5: Each corrected sample, in units of 2^-CFRAC pixel, is c[i] = floor((I[i]*2^(FRAC+1) - 2*meanQ - slopeQ*(2i-(NPIX-1))) / 2^(FRAC+1-CFRAC)). Exactly NPIX samples are formed per profile.
- R6: `amp` = floor((max c[i] - min c[i]) / 2) over the profile's corrected samples.
- R7: `isSum` = sum of c[i]*sineTable[i] and `icSum` = sum of c[i]*cosineTable[i]. A table write with `tabWe`=1 stores `tabSin` and `tabCos` at index `tabAddr`, and that entry is used by every later profile.
- R8: `done` is high for exactly one cycle. It rises on the clock edge NPIX+2 edges after the edge that samples the accepted end marker. `isSum`, `icSum` and `amp` change only on that edge and hold their values until the next one.
- R9: Valid pixels and markers that arrive between acceptance of an end marker and the `done` pulse are ignored and do not change the results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pixValid | input | 1 | Pixel present this cycle |
| pixSop | input | 1 | Pixel is the first of a profile |
| pixEop | input | 1 | Pixel is the last of a profile |
| pixData | input | PIX_W | Unsigned pixel intensity |
| tabWe | input | 1 | Coefficient table write enable |
| tabAddr | input | IDX_W | Coefficient table index |
| tabSin | input | TAB_W | Signed sine coefficient to store |
| tabCos | input | TAB_W | Signed cosine coefficient to store |
| done | output | 1 | One-cycle result strobe |
| isSum | output | ACC_W | Signed sine correlation sum |
| icSum | output | ACC_W | Signed cosine correlation sum |
| amp | output | C_W | Half peak-to-peak of corrected samples, CFRAC fraction bits |

## Verification
A slope or mean register that loaded the wrong sums shows at the next `done` in all three results at once. That pulse comes NPIX+2 cycles after the end marker, so a fit error cannot stay hidden past one profile. A capture counter that is off by one turns an accepted profile into a silent drop, or a short profile into a spurious `done`. Either one is visible within one profile window. Accumulators or extremes left over from an earlier profile make a second, different profile give results that depend on its predecessor. The back-to-back, restart and stray-pixel cases expose this on the very next pulse.

// File: rtl/profile_fit_pkg.sv
package profile_fit_pkg;

  typedef struct packed {
    logic capFirst;
    logic capWr;
    logic fitLoad;
    logic scanEn;
    logic scanFirst;
    logic outLoad;
  } fitStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAPTURE,
    ST_FIT,
    ST_SCAN,
    ST_DONE
  } fitState_t;

endpackage

// File: rtl/profile_coef_bank.sv
module profile_coef_bank #(
  parameter int NPIX  = 20,
  parameter int IDX_W = 5,
  parameter int TAB_W = 16
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [IDX_W-1:0]        wAddr,
  input  logic signed [TAB_W-1:0] wData,
  input  logic [IDX_W-1:0]        rAddr,
  output logic signed [TAB_W-1:0] rData
);

  logic signed [TAB_W-1:0] mem [NPIX];

  always_ff @(posedge clk) begin
    if (we) mem[wAddr] <= wData;
  end

  assign rData = mem[rAddr];

endmodule

// File: rtl/profile_fit_ctrl.sv
module profile_fit_ctrl
  import profile_fit_pkg::*;
#(
  parameter int NPIX  = 20,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pixValid,
  input  logic             pixSop,
  input  logic             pixEop,
  output fitStrobes_t      strb,
  output logic [IDX_W-1:0] capIdx,
  output logic [IDX_W-1:0] scanIdx
);

  localparam int CNT_W = IDX_W + 1;

  fitState_t        state, nxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [IDX_W-1:0] sIdx, sIdxNxt;

  always_comb begin
    strb    = '0;
    capIdx  = cnt[IDX_W-1:0];
    nxt     = state;
    cntNxt  = cnt;
    sIdxNxt = sIdx;
    unique case (state)
      ST_IDLE, ST_CAPTURE: begin
        if (pixValid) begin
          if (pixSop) begin
            // a start marker always opens a fresh profile at index 0
            strb.capWr    = 1'b1;
            strb.capFirst = 1'b1;
            capIdx        = '0;
            cntNxt        = CNT_W'(1);
            if (pixEop) nxt = (NPIX == 1) ? ST_FIT : ST_IDLE;
            else        nxt = ST_CAPTURE;
          end else if (state == ST_CAPTURE) begin
            if (cnt < CNT_W'(NPIX)) begin
              strb.capWr = 1'b1;
              cntNxt     = cnt + CNT_W'(1);
            end
            if (pixEop) nxt = (cnt == CNT_W'(NPIX - 1)) ? ST_FIT : ST_IDLE;
          end
        end
      end
      ST_FIT: begin
        strb.fitLoad = 1'b1;
        sIdxNxt      = '0;
        nxt          = ST_SCAN;
      end
      ST_SCAN: begin
        strb.scanEn    = 1'b1;
        strb.scanFirst = (sIdx == '0);
        if (sIdx == IDX_W'(NPIX - 1)) nxt = ST_DONE;
        else sIdxNxt = sIdx + IDX_W'(1);
      end
      ST_DONE: begin
        strb.outLoad = 1'b1;
        nxt          = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      sIdx  <= '0;
    end else begin
      state <= nxt;
      cnt   <= cntNxt;
      sIdx  <= sIdxNxt;
    end
  end

  assign scanIdx = sIdx;

endmodule

// File: rtl/profile_fit_dp.sv
module profile_fit_dp
  import profile_fit_pkg::*;
#(
  parameter int NPIX  = 20,
  parameter int IDX_W = 5,
  parameter int PIX_W = 12,
  parameter int TAB_W = 16,
  parameter int FRAC  = 20,
  parameter int CFRAC = 4,
  parameter int WIDE  = 48,
  parameter int C_W   = 19,
  parameter int ACC_W = 41
) (
  input  logic                    clk,
  input  logic                    rst,
  input  fitStrobes_t             strb,
  input  logic [IDX_W-1:0]        capIdx,
  input  logic [IDX_W-1:0]        scanIdx,
  input  logic [PIX_W-1:0]        pixData,
  input  logic signed [TAB_W-1:0] sinVal,
  input  logic signed [TAB_W-1:0] cosVal,
  output logic                    done,
  output logic signed [ACC_W-1:0] isSum,
  output logic signed [ACC_W-1:0] icSum,
  output logic [C_W-1:0]          amp
);

  localparam int    SHIFT     = FRAC + 1 - CFRAC;
  localparam longint ONE_Q    = longint'(1) << FRAC;
  localparam longint VAR2     = longint'(NPIX) * (longint'(NPIX) * NPIX - 1) / 6;
  localparam longint RECIP_V  = (ONE_Q + VAR2 / 2) / VAR2;
  localparam longint RECIP_N  = (ONE_Q + NPIX / 2) / NPIX;
  localparam logic signed [WIDE-1:0] K_RV  = WIDE'(RECIP_V);
  localparam logic signed [WIDE-1:0] K_RN  = WIDE'(RECIP_N);
  localparam logic signed [WIDE-1:0] K_NM1 = WIDE'(NPIX - 1);

  logic [PIX_W-1:0] pixBuf [NPIX];

  logic signed [WIDE-1:0] sumI, sumXY, slopeQ, meanQ;
  logic signed [WIDE-1:0] pixExt, capIdxExt, rawExt, dx2, covTwice, c2Q;
  logic signed [C_W-1:0]  cVal, cMax, cMin;
  logic signed [C_W:0]    ampDiff;
  logic signed [ACC_W-1:0] prodS, prodC, accS, accC;

  // capture side: raw pixel store and running sums
  assign pixExt    = WIDE'(pixData);
  assign capIdxExt = WIDE'(capIdx);

  always_ff @(posedge clk) begin
    if (strb.capWr) pixBuf[capIdx] <= pixData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sumI  <= '0;
      sumXY <= '0;
    end else if (strb.capWr) begin
      if (strb.capFirst) begin
        sumI  <= pixExt;
        sumXY <= '0;
      end else begin
        sumI  <= sumI + pixExt;
        sumXY <= sumXY + capIdxExt * pixExt;
      end
    end
  end

  // line fit: divisions replaced by constant reciprocals
  assign covTwice = (sumXY <<< 1) - K_NM1 * sumI;

  always_ff @(posedge clk) begin
    if (rst) begin
      slopeQ <= '0;
      meanQ  <= '0;
    end else if (strb.fitLoad) begin
      slopeQ <= covTwice * K_RV;
      meanQ  <= sumI * K_RN;
    end
  end

  // scan side: detrend one stored pixel per cycle
  assign rawExt = WIDE'(pixBuf[scanIdx]);
  assign dx2    = (WIDE'(scanIdx) <<< 1) - K_NM1;
  assign c2Q    = (rawExt <<< (FRAC + 1)) - (meanQ <<< 1) - slopeQ * dx2;
  assign cVal   = C_W'(c2Q >>> SHIFT);

  assign prodS = ACC_W'(cVal) * ACC_W'(sinVal);
  assign prodC = ACC_W'(cVal) * ACC_W'(cosVal);

  always_ff @(posedge clk) begin
    if (rst) begin
      accS <= '0;
      accC <= '0;
      cMax <= '0;
      cMin <= '0;
    end else if (strb.scanEn) begin
      if (strb.scanFirst) begin
        accS <= prodS;
        accC <= prodC;
        cMax <= cVal;
        cMin <= cVal;
      end else begin
        accS <= accS + prodS;
        accC <= accC + prodC;
        if (cVal > cMax) cMax <= cVal;
        if (cVal < cMin) cMin <= cVal;
      end
    end
  end

  assign ampDiff = (C_W + 1)'(cMax) - (C_W + 1)'(cMin);

  always_ff @(posedge clk) begin
    if (rst) begin
      isSum <= '0;
      icSum <= '0;
      amp   <= '0;
      done  <= 1'b0;
    end else begin
      done <= strb.outLoad;
      if (strb.outLoad) begin
        isSum <= accS;
        icSum <= accC;
        amp   <= C_W'(ampDiff >>> 1);
      end
    end
  end

endmodule

// File: rtl/profile_fit_top.sv
module profile_fit_top
  import profile_fit_pkg::*;
#(
  parameter int NPIX  = 20,
  parameter int PIX_W = 12,
  parameter int TAB_W = 16,
  parameter int FRAC  = 20,
  parameter int CFRAC = 4,
  localparam int IDX_W = (NPIX > 1) ? $clog2(NPIX) : 1,
  localparam int C_W   = PIX_W + CFRAC + 3,
  localparam int ACC_W = C_W + TAB_W + IDX_W + 1,
  localparam int WIDE  = PIX_W + FRAC + 2 * IDX_W + 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    pixValid,
  input  logic                    pixSop,
  input  logic                    pixEop,
  input  logic [PIX_W-1:0]        pixData,
  input  logic                    tabWe,
  input  logic [IDX_W-1:0]        tabAddr,
  input  logic signed [TAB_W-1:0] tabSin,
  input  logic signed [TAB_W-1:0] tabCos,
  output logic                    done,
  output logic signed [ACC_W-1:0] isSum,
  output logic signed [ACC_W-1:0] icSum,
  output logic [C_W-1:0]          amp
);

  fitStrobes_t             strb;
  logic [IDX_W-1:0]        capIdx, scanIdx;
  logic signed [TAB_W-1:0] sinVal, cosVal;

  profile_fit_ctrl #(.NPIX(NPIX), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst(rst), .pixValid(pixValid), .pixSop(pixSop), .pixEop(pixEop),
    .strb(strb), .capIdx(capIdx), .scanIdx(scanIdx)
  );

  profile_coef_bank #(.NPIX(NPIX), .IDX_W(IDX_W), .TAB_W(TAB_W)) u_sinBank (
    .clk(clk), .we(tabWe), .wAddr(tabAddr), .wData(tabSin),
    .rAddr(scanIdx), .rData(sinVal)
  );

  profile_coef_bank #(.NPIX(NPIX), .IDX_W(IDX_W), .TAB_W(TAB_W)) u_cosBank (
    .clk(clk), .we(tabWe), .wAddr(tabAddr), .wData(tabCos),
    .rAddr(scanIdx), .rData(cosVal)
  );

  profile_fit_dp #(
    .NPIX(NPIX), .IDX_W(IDX_W), .PIX_W(PIX_W), .TAB_W(TAB_W), .FRAC(FRAC),
    .CFRAC(CFRAC), .WIDE(WIDE), .C_W(C_W), .ACC_W(ACC_W)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .capIdx(capIdx), .scanIdx(scanIdx),
    .pixData(pixData), .sinVal(sinVal), .cosVal(cosVal),
    .done(done), .isSum(isSum), .icSum(icSum), .amp(amp)
  );

endmodule

// File: rtl/profile_fit_chk.sv
module profile_fit_chk #(
  parameter int NPIX  = 20,
  parameter int ACC_W = 41,
  parameter int C_W   = 19
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    done,
  input logic signed [ACC_W-1:0] isSum,
  input logic signed [ACC_W-1:0] icSum,
  input logic [C_W-1:0]          amp,
  input logic                    capWr,
  input logic                    fitLoad,
  input logic                    scanEn,
  input logic                    outLoad
);

  localparam int SC_W = $clog2(NPIX + 1) + 1;

  logic [SC_W-1:0] scanCnt;

  always_ff @(posedge clk) begin
    if (rst)          scanCnt <= '0;
    else if (fitLoad) scanCnt <= '0;
    else if (scanEn)  scanCnt <= scanCnt + SC_W'(1);
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R8

  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(isSum) && $stable(icSum) && $stable(amp)));  // R8

  AST_SCAN_COUNT: assert property (@(posedge clk) disable iff (rst)
    outLoad |-> (scanCnt == SC_W'(NPIX)));  // R5

  AST_FIT_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    fitLoad |-> $past(capWr));  // R3

  AST_NO_CAPTURE_BUSY: assert property (@(posedge clk) disable iff (rst)
    scanEn |-> !capWr);  // R9

endmodule

bind profile_fit_top profile_fit_chk #(.NPIX(NPIX), .ACC_W(ACC_W), .C_W(C_W)) u_chk (
  .clk(clk), .rst(rst), .done(done), .isSum(isSum), .icSum(icSum), .amp(amp),
  .capWr(strb.capWr), .fitLoad(strb.fitLoad), .scanEn(strb.scanEn),
  .outLoad(strb.outLoad)
);

// File: tb/sim_profile_fit_top.sv
module sim_profile_fit_top;

  localparam int NPIX  = 20;
  localparam int PIX_W = 12;
  localparam int TAB_W = 16;
  localparam int FRAC  = 20;
  localparam int CFRAC = 4;
  localparam int IDX_W = 5;
  localparam int C_W   = PIX_W + CFRAC + 3;
  localparam int ACC_W = C_W + TAB_W + IDX_W + 1;
  localparam int SHIFT = FRAC + 1 - CFRAC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pixValid = 1'b0, pixSop = 1'b0, pixEop = 1'b0;
  logic [PIX_W-1:0] pixData = '0;
  logic tabWe = 1'b0;
  logic [IDX_W-1:0] tabAddr = '0;
  logic signed [TAB_W-1:0] tabSin = '0, tabCos = '0;
  logic done;
  logic signed [ACC_W-1:0] isSum, icSum;
  logic [C_W-1:0] amp;

  always #4 clk = ~clk;

  profile_fit_top #(.NPIX(NPIX), .PIX_W(PIX_W), .TAB_W(TAB_W), .FRAC(FRAC), .CFRAC(CFRAC)) u0 (
    .clk(clk), .rst(rst), .pixValid(pixValid), .pixSop(pixSop), .pixEop(pixEop),
    .pixData(pixData), .tabWe(tabWe), .tabAddr(tabAddr), .tabSin(tabSin), .tabCos(tabCos),
    .done(done), .isSum(isSum), .icSum(icSum), .amp(amp)
  );

  int nChk = 0;
  int nErr = 0;
  int sinT [NPIX];
  int cosT [NPIX];
  longint expIs, expIc, expAmp;

  task automatic chk(input string req, input string what, input longint got, input longint exp);
    nChk++;
    if (got != exp) begin
      nErr++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // expected results from the fit, detrend and correlation formulas (R4-R7)
  function automatic void model(input int p[NPIX]);
    longint s = 0, t = 0, var2, rv, rn, slope, mean, c2, c, mx, mn;
    for (int i = 0; i < NPIX; i++) begin
      s += p[i];
      t += longint'(i) * p[i];
    end
    var2  = longint'(NPIX) * (NPIX * NPIX - 1) / 6;
    rv    = ((longint'(1) << FRAC) + var2 / 2) / var2;
    rn    = ((longint'(1) << FRAC) + NPIX / 2) / NPIX;
    slope = (2 * t - longint'(NPIX - 1) * s) * rv;
    mean  = s * rn;
    expIs = 0;
    expIc = 0;
    mx = 0;
    mn = 0;
    for (int i = 0; i < NPIX; i++) begin
      c2 = (longint'(p[i]) <<< (FRAC + 1)) - 2 * mean - slope * (2 * i - (NPIX - 1));
      c  = c2 >>> SHIFT;
      if (i == 0 || c > mx) mx = c;
      if (i == 0 || c < mn) mn = c;
      expIs += c * sinT[i];
      expIc += c * cosT[i];
    end
    expAmp = (mx - mn) >>> 1;
  endfunction

  task automatic loadTables(input int s[NPIX], input int c[NPIX]);
    for (int i = 0; i < NPIX; i++) begin
      @(negedge clk);
      tabWe = 1'b1;
      tabAddr = IDX_W'(i);
      tabSin = TAB_W'(s[i]);
      tabCos = TAB_W'(c[i]);
      sinT[i] = s[i];
      cosT[i] = c[i];
    end
    @(negedge clk);
    tabWe = 1'b0;
  endtask

  // drives n pixels (start on the first, end on the last), then watches done
  task automatic runProfile(input int p[NPIX], input int n, input bit junk,
                            output int lat, output int nDone);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pixValid = 1'b1;
      pixSop = (i == 0);
      pixEop = (i == n - 1);
      pixData = PIX_W'(p[i % NPIX]);
    end
    lat = -1;
    nDone = 0;
    // c=1 observes the state after the edge that sampled the end marker
    for (int c = 1; c <= 3 * NPIX; c++) begin
      @(negedge clk);
      if (junk && c <= NPIX) begin
        pixValid = 1'b1;
        pixSop = (c % 3 == 0);
        pixEop = (c % 4 == 0);
        pixData = PIX_W'(c * 97);
      end else begin
        pixValid = 1'b0;
        pixSop = 1'b0;
        pixEop = 1'b0;
      end
      if (done) begin
        nDone++;
        if (lat < 0) lat = c;
      end
    end
  endtask

  task automatic checkResults(input string req, input int p[NPIX]);
    model(p);
    chk(req, "isSum", isSum, expIs);
    chk(req, "icSum", icSum, expIc);
    chk(req, "amp", longint'(amp), expAmp);
  endtask

  int flatP [NPIX];
  int rampP [NPIX];
  int fringeP [NPIX];
  int fringe2P [NPIX];
  int sA [NPIX];
  int cA [NPIX];

  task automatic t_reset();
    chk("R1", "done after reset", longint'(done), 0);
    chk("R1", "isSum after reset", isSum, 0);
    chk("R1", "icSum after reset", icSum, 0);
    chk("R1", "amp after reset", longint'(amp), 0);
  endtask

  task automatic t_flat();
    int lat, nd;
    runProfile(flatP, NPIX, 1'b0, lat, nd);
    chk("R8", "flat latency", lat, NPIX + 3);
    chk("R8", "flat done pulses", nd, 1);
    checkResults("R5 flat", flatP);
  endtask

  task automatic t_ramp();
    int lat, nd;
    runProfile(rampP, NPIX, 1'b0, lat, nd);
    chk("R4", "ramp done pulses", nd, 1);
    checkResults("R4 ramp", rampP);
  endtask

  task automatic t_fringe();
    int lat, nd;
    runProfile(fringeP, NPIX, 1'b0, lat, nd);
    chk("R8", "fringe latency", lat, NPIX + 3);
    checkResults("R6 R7 fringe", fringeP);
  endtask

  task automatic t_badLength();
    int lat, nd;
    longint oldIs, oldIc, oldAmp;
    oldIs = isSum;
    oldIc = icSum;
    oldAmp = amp;
    runProfile(fringe2P, NPIX - 1, 1'b0, lat, nd);
    chk("R3", "short profile done pulses", nd, 0);
    runProfile(fringe2P, NPIX + 1, 1'b0, lat, nd);
    chk("R3", "long profile done pulses", nd, 0);
    chk("R3", "isSum kept after drops", isSum, oldIs);
    chk("R3", "icSum kept after drops", icSum, oldIc);
    chk("R3", "amp kept after drops", longint'(amp), oldAmp);
  endtask

  task automatic t_strayAndRestart();
    int lat, nd;
    // valid pixels with no open profile, including an end marker
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      pixValid = 1'b1;
      pixSop = 1'b0;
      pixEop = (i == 5);
      pixData = PIX_W'(4000 - i);
    end
    // an unfinished profile that the next start marker must discard
    for (int i = 0; i < 7; i++) begin
      @(negedge clk);
      pixValid = 1'b1;
      pixSop = (i == 0);
      pixEop = 1'b0;
      pixData = PIX_W'(3900);
    end
    runProfile(fringe2P, NPIX, 1'b0, lat, nd);
    chk("R2", "restart done pulses", nd, 1);
    checkResults("R2 restart", fringe2P);
  endtask

  task automatic t_busyJunk();
    int lat, nd;
    runProfile(fringeP, NPIX, 1'b1, lat, nd);
    chk("R9", "junk run latency", lat, NPIX + 3);
    chk("R9", "junk run done pulses", nd, 1);
    checkResults("R9 junk", fringeP);
    runProfile(rampP, NPIX, 1'b0, lat, nd);
    checkResults("R9 follow-up", rampP);
  endtask

  task automatic t_tableSwap();
    int lat, nd;
    int s2 [NPIX];
    int c2 [NPIX];
    for (int i = 0; i < NPIX; i++) begin
      s2[i] = -cA[i];
      c2[i] = sA[i] / 2;
    end
    loadTables(s2, c2);
    runProfile(fringeP, NPIX, 1'b0, lat, nd);
    checkResults("R7 new tables", fringeP);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NPIX; i++) begin
      flatP[i]    = 1500;
      rampP[i]    = 100 + 37 * i;
      fringeP[i]  = $rtoi(2000.0 + 25.0 * i + 900.0 * $cos(6.2831853 * i / 5.3 + 0.7));
      fringe2P[i] = $rtoi(3000.0 - 40.0 * i + 600.0 * $cos(6.2831853 * i / 4.1 - 1.9));
      sA[i]       = $rtoi(16000.0 * $sin(6.2831853 * i / 5.3));
      cA[i]       = $rtoi(16000.0 * $cos(6.2831853 * i / 5.3));
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    loadTables(sA, cA);
    t_flat();
    t_ramp();
    t_fringe();
    t_badLength();
    t_strayAndRestart();
    t_busyJunk();
    t_tableSwap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

endmodule